// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the data movement of one DMA channel. Software arms the channel with an enable pulse. The channel then waits for a request from the source chosen by its selection: a software strobe, one of several peripheral request lines, or an event input. Each byte is moved as a read access followed by a write access on a simple memory bus, and each access is held until the bus acknowledges it. Bytes are grouped into bursts of a selectable length. Bursts make up a block of programmable size, and one or more blocks make up a transaction.

Two trigger modes are available. In the default mode a single request moves a whole block. In single-shot mode each request moves one burst. With repeat mode on, the channel chains blocks up to a programmed count and needs no new request between them. A request that arrives while data is moving is held in a one-deep latch and any further requests are dropped. One-cycle pulses mark the end of each burst, each block and the whole transaction, and the channel disarms itself at the end of the transaction. Address generation and arbitration between channels belong to other blocks.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, ch_en, bus_rd, bus_wr, req_pending, burst_done, block_done and txn_done are all low.
- R2: An en_set pulse while ch_en is low raises ch_en on the next cycle. The channel makes no bus access until a request arrives from the selected source.
- R3: cfg_trig_sel picks the request source: 0 is sw_trig, 1 is periph_req[cfg_periph_idx], 2 is evt_trig, and 3 selects no source. Requests on sources that are not selected have no effect.
- R4: A peripheral line whose bit in the PERIPH_PRESENT parameter is 0 never starts the channel, even when it is selected and pulses.
- R5: Each byte is a read access followed by a write access. bus_rd stays high until a cycle with bus_ack, bus_wr follows in the next cycle and stays high until bus_ack, and the two are never high together.
- R6: A burst is 2**cfg_burst_sel bytes. burst_done is a one-cycle pulse in the cycle after the final write acknowledge of each burst.
- R7: In the default mode (cfg_single = 0), one request moves the whole block, burst after burst, with no further request. block_done pulses together with the last burst_done of the block.
- R8: With repeat mode off, a transaction is one block. txn_done pulses once in the cycle after the last write acknowledge, and ch_en is low from that cycle on.
- R9: With repeat mode on, a transaction is cfg_rep_cnt blocks (a count of 0 is treated as 1). In the default mode the blocks follow each other without requests, and txn_done pulses only with the final block_done.
- R10: In single-shot mode (cfg_single = 1), each request moves exactly one burst. The channel then waits, still enabled, for the next request, including across a block boundary.
- R11: A request that arrives while an access is in progress sets req_pending on the next cycle. In single-shot mode, a pending request starts the next burst directly after the current burst ends (bus_rd in the following cycle) and req_pending clears.
- R12: Only one request is held. Requests that arrive while one is already pending are dropped and move no extra data.
- R13: The end of a transaction clears req_pending. Requests that arrive while ch_en is low are ignored.
- R14: Burst length, block size, repeat count, mode and repeat bits are sampled at the enabling en_set pulse. Later changes to them, and en_set pulses while ch_en is high, do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_set | input | 1 | Arm pulse; takes effect only while the channel is disarmed |
| cfg_single | input | 1 | 1: each request moves one burst; 0: each request moves one block |
| cfg_repeat | input | 1 | 1: transaction spans cfg_rep_cnt blocks |
| cfg_burst_sel | input | SEL_W | Burst length exponent (length 2**value bytes) |
| cfg_blk_size | input | BLK_W | Block size in bytes, a nonzero multiple of the burst length |
| cfg_rep_cnt | input | REP_W | Number of blocks when repeat mode is on |
| cfg_trig_sel | input | 2 | Request source selection |
| cfg_periph_idx | input | IDX_W | Peripheral line index used when source 1 is selected |
| sw_trig | input | 1 | Software request strobe |
| periph_req | input | NUM_PERIPH | Peripheral request lines |
| evt_trig | input | 1 | Event request input |
| bus_ack | input | 1 | Bus acknowledge for the current access |
| bus_rd | output | 1 | Read access request |
| bus_wr | output | 1 | Write access request |
| ch_en | output | 1 | Channel armed |
| req_pending | output | 1 | One request held pending |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| block_done | output | 1 | One-cycle pulse at the end of a block |
| txn_done | output | 1 | One-cycle pulse at the end of the transaction |

## Verification
The assertions rely on the block size being a nonzero whole multiple of the burst length. If it were not, the burst and block counters would fall out of step and the pulse relations would break. They also take requests and en_set to be sampled only on clock edges, and bus_ack to matter only while an access is asserted. The stimulus programs only sizes such as 12 bytes with 4-byte bursts or 8 bytes with 2-byte bursts. It drives every input just after the falling edge and varies bus_ack pseudo-randomly, so the access handshake sees stalls of different lengths.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      TRG_SW     = 2'd0,
      TRG_PERIPH = 2'd1,
      TRG_EVENT  = 2'd2,
      TRG_NONE   = 2'd3
   } trg_sel_e;

   typedef enum logic [1:0] {
      SQ_OFF  = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_RD   = 2'd2,
      SQ_WR   = 2'd3
   } sq_state_e;

endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
   import dma_seq_pkg::*;
#(
   parameter int NUM_PERIPH = 4,
   parameter logic [NUM_PERIPH-1:0] PERIPH_PRESENT = '1,
   localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
   input  logic [1:0]            sel,
   input  logic [IDX_W-1:0]      idx,
   input  logic                  sw_trig,
   input  logic [NUM_PERIPH-1:0] periph_req,
   input  logic                  evt_trig,
   output logic                  trig
);

   logic [NUM_PERIPH-1:0] live;
   logic                  periph_hit;

   // lines missing from this build are tied off
   assign live = periph_req & PERIPH_PRESENT;

   generate
      if ((1 << IDX_W) == NUM_PERIPH) begin : g_full_idx
         assign periph_hit = live[idx];
      end else begin : g_part_idx
         assign periph_hit = (32'(idx) < NUM_PERIPH) ? live[idx] : 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (trg_sel_e'(sel))
         TRG_SW:     trig = sw_trig;
         TRG_PERIPH: trig = periph_hit;
         TRG_EVENT:  trig = evt_trig;
         default:    trig = 1'b0;
      endcase
   end

endmodule

// File: rtl/dma_pend_latch.sv
module dma_pend_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   input  logic consume,
   output logic pend
);

   logic pend_n;

   // one-deep: a set while already held is simply lost
   always_comb begin
      if (clr)          pend_n = 1'b0;
      else if (consume) pend_n = set;
      else              pend_n = pend | set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_n;
   end

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
   parameter int SEL_W = 2,
   parameter int BLK_W = 16,
   parameter int REP_W = 8,
   localparam int BEAT_W = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] cfg_burst_sel,
   input  logic [BLK_W-1:0] cfg_blk_size,
   input  logic [REP_W-1:0] cfg_rep_cnt,
   input  logic             cfg_repeat,
   input  logic             byte_done,
   output logic             last_beat,
   output logic             last_byte,
   output logic             last_blk
);

   logic [BEAT_W-1:0] len_m1_in, len_m1_q, beat_q;
   logic [BLK_W-1:0]  size_m1_q, blk_q;
   logic [REP_W-1:0]  rep_q, rep_init;

   // burst length minus one is a thermometer code of the exponent
   generate
      for (genvar k = 0; k < BEAT_W; k++) begin : g_len
         assign len_m1_in[k] = (32'(cfg_burst_sel) > k);
      end
   endgenerate

   assign rep_init = (!cfg_repeat || cfg_rep_cnt == '0) ? '0 : cfg_rep_cnt - 1'b1;

   assign last_beat = (beat_q == '0);
   assign last_byte = (blk_q == '0);
   assign last_blk  = (rep_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_m1_q  <= '0;
         beat_q    <= '0;
         size_m1_q <= '0;
         blk_q     <= '0;
         rep_q     <= '0;
      end else if (load) begin
         len_m1_q  <= len_m1_in;
         beat_q    <= len_m1_in;
         size_m1_q <= cfg_blk_size - 1'b1;
         blk_q     <= cfg_blk_size - 1'b1;
         rep_q     <= rep_init;
      end else if (byte_done) begin
         beat_q <= last_beat ? len_m1_q : beat_q - 1'b1;
         blk_q  <= last_byte ? size_m1_q : blk_q - 1'b1;
         if (last_byte && !last_blk) rep_q <= rep_q - 1'b1;
      end
   end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int NUM_PERIPH = 4,
   parameter logic [NUM_PERIPH-1:0] PERIPH_PRESENT = '1,
   parameter int SEL_W = 2,
   parameter int BLK_W = 16,
   parameter int REP_W = 8,
   localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_set,
   input  logic                  cfg_single,
   input  logic                  cfg_repeat,
   input  logic [SEL_W-1:0]      cfg_burst_sel,
   input  logic [BLK_W-1:0]      cfg_blk_size,
   input  logic [REP_W-1:0]      cfg_rep_cnt,
   input  logic [1:0]            cfg_trig_sel,
   input  logic [IDX_W-1:0]      cfg_periph_idx,
   input  logic                  sw_trig,
   input  logic [NUM_PERIPH-1:0] periph_req,
   input  logic                  evt_trig,
   input  logic                  bus_ack,
   output logic                  bus_rd,
   output logic                  bus_wr,
   output logic                  ch_en,
   output logic                  req_pending,
   output logic                  burst_done,
   output logic                  block_done,
   output logic                  txn_done
);

   initial begin
      assert (NUM_PERIPH >= 1) else $error("NUM_PERIPH must be at least 1");
      assert (SEL_W >= 1 && SEL_W <= 4) else $error("SEL_W out of range");
      assert (BLK_W >= 2) else $error("BLK_W too small");
      assert (REP_W >= 1) else $error("REP_W too small");
   end

   sq_state_e st, ns;
   logic trig, busy, load, byte_done;
   logic last_beat, last_byte, last_blk;
   logic end_burst, end_block, end_txn;
   logic single_q, pend, consume;

   dma_trig_sel #(
      .NUM_PERIPH     (NUM_PERIPH),
      .PERIPH_PRESENT (PERIPH_PRESENT)
   ) u_trig (
      .sel        (cfg_trig_sel),
      .idx        (cfg_periph_idx),
      .sw_trig    (sw_trig),
      .periph_req (periph_req),
      .evt_trig   (evt_trig),
      .trig       (trig)
   );

   dma_xfer_cnt #(
      .SEL_W (SEL_W),
      .BLK_W (BLK_W),
      .REP_W (REP_W)
   ) u_cnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (load),
      .cfg_burst_sel (cfg_burst_sel),
      .cfg_blk_size  (cfg_blk_size),
      .cfg_rep_cnt   (cfg_rep_cnt),
      .cfg_repeat    (cfg_repeat),
      .byte_done     (byte_done),
      .last_beat     (last_beat),
      .last_byte     (last_byte),
      .last_blk      (last_blk)
   );

   dma_pend_latch u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (end_txn),
      .set     (trig & busy),
      .consume (consume),
      .pend    (pend)
   );

   assign busy      = (st == SQ_RD) || (st == SQ_WR);
   assign load      = (st == SQ_OFF) && en_set;
   assign byte_done = (st == SQ_WR) && bus_ack;
   assign end_burst = byte_done && last_beat;
   assign end_block = byte_done && last_byte;
   assign end_txn   = end_block && last_blk;
   assign consume   = end_burst && single_q && pend && !end_txn;

   always_comb begin
      ns = st;
      unique case (st)
         SQ_OFF:  if (en_set) ns = SQ_WAIT;
         SQ_WAIT: if (trig) ns = SQ_RD;
         SQ_RD:   if (bus_ack) ns = SQ_WR;
         SQ_WR: begin
            if (bus_ack) begin
               if (end_txn)                       ns = SQ_OFF;
               else if (!last_beat || !single_q)  ns = SQ_RD;
               else if (pend)                     ns = SQ_RD;
               else                               ns = SQ_WAIT;
            end
         end
         default: ns = SQ_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_OFF;
         single_q   <= 1'b0;
         burst_done <= 1'b0;
         block_done <= 1'b0;
         txn_done   <= 1'b0;
      end else begin
         st         <= ns;
         if (load) single_q <= cfg_single;
         burst_done <= end_burst;
         block_done <= end_block;
         txn_done   <= end_txn;
      end
   end

   assign bus_rd      = (st == SQ_RD);
   assign bus_wr      = (st == SQ_WR);
   assign ch_en       = (st != SQ_OFF);
   assign req_pending = pend;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_ack,
   input logic bus_rd,
   input logic bus_wr,
   input logic ch_en,
   input logic req_pending,
   input logic burst_done,
   input logic block_done,
   input logic txn_done
);

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R5
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bus_rd && !bus_ack |=> bus_rd); // R5
   AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n) bus_rd && bus_ack |=> bus_wr); // R5
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bus_wr && !bus_ack |=> bus_wr); // R5
   AST_BURST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) burst_done |=> !burst_done); // R6
   AST_BLOCK_ON_BURST: assert property (@(posedge clk) disable iff (!rst_n) block_done |-> burst_done); // R7
   AST_TXN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) txn_done |-> !ch_en); // R8
   AST_TXN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) txn_done |=> !txn_done); // R8
   AST_TXN_ON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) txn_done |-> block_done); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !ch_en |-> !bus_rd && !bus_wr); // R2
   AST_NO_PEND_OFF: assert property (@(posedge clk) disable iff (!rst_n) !ch_en |-> !req_pending); // R13

endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (.*);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;

   localparam int NP = 4;
   localparam logic [NP-1:0] PRESENT = 4'b1011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_set = 0, cfg_single = 0, cfg_repeat = 0;
   logic [1:0]  cfg_burst_sel = 0;
   logic [15:0] cfg_blk_size = 16'd4;
   logic [7:0]  cfg_rep_cnt = 0;
   logic [1:0]  cfg_trig_sel = 0;
   logic [1:0]  cfg_periph_idx = 0;
   logic sw_trig = 0, evt_trig = 0, bus_ack = 0;
   logic [NP-1:0] periph_req = '0;
   logic bus_rd, bus_wr, ch_en, req_pending, burst_done, block_done, txn_done;

   int checks = 0, errors = 0, cycles = 0;
   int n_wr = 0, n_rd = 0, n_burst = 0, n_block = 0, n_txn = 0;

   // reference model state
   bit m_on = 0, m_pend = 0, m_bu = 0, m_bl = 0, m_tx = 0, k_single = 0;
   int m_mode = 0;  // 0 waiting, 1 read, 2 write
   int k_len = 1, k_size = 1, k_blocks = 1, n_b = 0, n_k = 0, n_blk = 0;

   always #5 clk = ~clk;

   dma_chan_seq #(.NUM_PERIPH(NP), .PERIPH_PRESENT(PRESENT)) uut (.*);

   function automatic bit model_trig();
      case (cfg_trig_sel)
         2'd0: return sw_trig;
         2'd1: return periph_req[cfg_periph_idx] & PRESENT[cfg_periph_idx];
         2'd2: return evt_trig;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_on = 0; m_mode = 0; m_pend = 0; m_bu = 0; m_bl = 0; m_tx = 0;
      end else begin
         bit t, ps, np, eb;
         t = model_trig();
         m_bu = 0; m_bl = 0; m_tx = 0;
         if (!m_on) begin
            if (en_set) begin
               m_on = 1; m_mode = 0;
               k_len = 1 << cfg_burst_sel;
               k_size = int'(cfg_blk_size);
               k_blocks = (cfg_repeat && cfg_rep_cnt != 0) ? int'(cfg_rep_cnt) : 1;
               k_single = cfg_single;
               n_b = 0; n_k = 0; n_blk = 0;
            end
         end else begin
            ps = t && (m_mode != 0);
            np = m_pend || ps;
            case (m_mode)
               0: if (t) m_mode = 1;
               1: if (bus_ack) m_mode = 2;
               default: if (bus_ack) begin
                  n_b++; n_k++; eb = 0;
                  if (n_b == k_len) begin eb = 1; m_bu = 1; n_b = 0; end
                  if (n_k == k_size) begin
                     m_bl = 1; n_k = 0; n_blk++;
                     if (n_blk == k_blocks) m_tx = 1;
                  end
                  if (m_tx) begin m_on = 0; np = 0; m_mode = 0; end
                  else if (!eb || !k_single) m_mode = 1;
                  else if (m_pend) begin m_mode = 1; np = ps; end
                  else m_mode = 0;
               end
            endcase
            m_pend = np;
         end
      end
   end

   task automatic cmp(string req, string nm, logic got, bit exp);
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, nm, got, exp, cycles);
      end
   endtask

   // per-cycle comparison, activity counters and bus acknowledge driver
   always @(negedge clk) begin
      cycles++;
      checks++;
      cmp("R5", "bus_rd", bus_rd, m_on && m_mode == 1);
      cmp("R5", "bus_wr", bus_wr, m_on && m_mode == 2);
      cmp("R8", "ch_en", ch_en, m_on);
      cmp("R11", "req_pending", req_pending, m_pend);
      cmp("R6", "burst_done", burst_done, m_bu);
      cmp("R7", "block_done", block_done, m_bl);
      cmp("R9", "txn_done", txn_done, m_tx);
      if (bus_wr && bus_ack) n_wr++;
      if (bus_rd) n_rd++;
      if (burst_done) n_burst++;
      if (block_done) n_block++;
      if (txn_done) n_txn++;
      bus_ack = ($urandom_range(0, 3) != 0);
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw_trig = 1;
      @(negedge clk); sw_trig = 0;
   endtask

   task automatic arm(bit single, bit rpt, logic [1:0] bsel, int size, int reps, logic [1:0] tsel);
      @(negedge clk);
      cfg_single = single; cfg_repeat = rpt; cfg_burst_sel = bsel;
      cfg_blk_size = 16'(size); cfg_rep_cnt = 8'(reps); cfg_trig_sel = tsel;
      en_set = 1;
      @(negedge clk); en_set = 0;
   endtask

   task automatic wait_off();
      for (int i = 0; i < 2000 && ch_en; i++) @(negedge clk);
   endtask

   task automatic wait_bursts(int target);
      for (int i = 0; i < 2000 && n_burst < target; i++) @(negedge clk);
   endtask

   task automatic wait_rd();
      for (int i = 0; i < 200 && !bus_rd; i++) @(negedge clk);
   endtask

   initial begin
      int w0, r0, b0, k0, t0;
      cyc(2);
      check("R1 reset outputs", int'({bus_rd, bus_wr, ch_en, req_pending, burst_done, block_done, txn_done}), 0);
      rst_n = 1;
      cyc(1);
      check("R1 after release", int'({ch_en, bus_rd, req_pending}), 0);

      // R2/R6/R7/R8: default mode, 4-byte bursts, 12-byte block
      arm(0, 0, 2'd2, 12, 0, 2'd0);
      check("R2 armed", int'(ch_en), 1);
      r0 = n_rd; cyc(6);
      check("R2 no access before request", n_rd - r0, 0);
      w0 = n_wr; b0 = n_burst; k0 = n_block; t0 = n_txn;
      pulse_sw(); wait_off(); cyc(2);
      check("R7 bytes per block", n_wr - w0, 12);
      check("R6 bursts per block", n_burst - b0, 3);
      check("R7 blocks", n_block - k0, 1);
      check("R8 txn pulses", n_txn - t0, 1);

      // R9/R14: event source, repeat 2, config changed while running
      arm(0, 1, 2'd2, 12, 2, 2'd2);
      w0 = n_wr; k0 = n_block; t0 = n_txn;
      @(negedge clk); evt_trig = 1; @(negedge clk); evt_trig = 0;
      wait_rd(); cfg_blk_size = 16'd4; cfg_rep_cnt = 8'd5; en_set = 1;
      @(negedge clk); en_set = 0;
      wait_off(); cyc(2);
      check("R9 bytes over two blocks", n_wr - w0, 24);
      check("R9 blocks chained", n_block - k0, 2);
      check("R14 single txn despite changes", n_txn - t0, 1);

      // R9: repeat with count 0 behaves as one block
      arm(0, 1, 2'd3, 8, 0, 2'd0);
      w0 = n_wr; pulse_sw(); wait_off(); cyc(2);
      check("R9 zero count is one block", n_wr - w0, 8);

      // R4/R3: absent peripheral line, then no-source, then a present line
      arm(0, 0, 2'd0, 4, 0, 2'd1);
      cfg_periph_idx = 2'd2;
      r0 = n_rd;
      @(negedge clk); periph_req = 4'b0100; cyc(5); periph_req = '0; cyc(10);
      check("R4 absent line ignored", n_rd - r0, 0);
      check("R4 still armed", int'(ch_en), 1);
      cfg_trig_sel = 2'd3; pulse_sw();
      @(negedge clk); evt_trig = 1; @(negedge clk); evt_trig = 0; cyc(8);
      check("R3 no source selected", n_rd - r0, 0);
      cfg_trig_sel = 2'd0;
      @(negedge clk); evt_trig = 1; periph_req = 4'b1111; @(negedge clk); evt_trig = 0; periph_req = '0; cyc(8);
      check("R3 unselected sources ignored", n_rd - r0, 0);
      cfg_trig_sel = 2'd1; cfg_periph_idx = 2'd1; w0 = n_wr;
      @(negedge clk); periph_req = 4'b0010; @(negedge clk); periph_req = '0;
      wait_off(); cyc(2);
      check("R3 present peripheral line", n_wr - w0, 4);

      // R10/R11/R12: single-shot, 2-byte bursts, 8-byte block
      cfg_trig_sel = 2'd0;
      arm(1, 0, 2'd1, 8, 0, 2'd0);
      w0 = n_wr; b0 = n_burst;
      pulse_sw(); wait_rd();
      sw_trig = 1; @(negedge clk);
      check("R11 pending held", int'(req_pending), 1);
      sw_trig = 1; @(negedge clk); sw_trig = 0;
      wait_bursts(b0 + 2); cyc(10);
      check("R12 extra request dropped", n_wr - w0, 4);
      check("R11 pending consumed", int'(req_pending), 0);
      check("R10 waits armed", int'(ch_en), 1);
      pulse_sw(); wait_bursts(b0 + 3); cyc(6);
      check("R10 one burst per request", n_wr - w0, 6);
      pulse_sw(); wait_off(); cyc(2);
      check("R10 block completes", n_wr - w0, 8);

      // R10: single-shot with repeat crosses block boundaries on requests
      arm(1, 1, 2'd0, 2, 2, 2'd0);
      w0 = n_wr; b0 = n_burst; t0 = n_txn;
      for (int i = 1; i <= 4; i++) begin
         pulse_sw(); wait_bursts(b0 + i); cyc(4);
      end
      cyc(2);
      check("R10 four requests four bytes", n_wr - w0, 4);
      check("R10 one txn", n_txn - t0, 1);

      // R13: pending dropped at end, requests while disarmed ignored
      arm(0, 0, 2'd1, 4, 0, 2'd0);
      pulse_sw(); wait_rd(); pulse_sw();
      wait_off(); cyc(1);
      check("R13 pending cleared at end", int'(req_pending), 0);
      r0 = n_rd; pulse_sw(); cyc(10);
      check("R13 request while disarmed", n_rd - r0, 0);
      check("R13 stays disarmed", int'(ch_en), 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule